// File: doc/BRIEF.md
# Auxiliary Memory Transfer Setup Registers

This block is the register front end of a block-transfer path between main memory and a secondary (auxiliary) memory. Software programs a 32-bit main-memory address, a 32-bit auxiliary address and a 32-bit byte count, each split into an upper and a lower 16-bit register. The lower halves of all three are forced to 32-byte alignment on write. Writing the lower half of the count launches the transfer: the block raises a single-cycle start pulse and presents the three 32-bit values to an external transfer engine.

The bus side carries halfword and word accesses within a 4 KB offset window. A word access is treated as two halfword accesses, the upper halfword going to the word offset and the lower halfword to the offset plus two. Three further halfword registers (info, mode and refresh) are plain storage that reads back unchanged. Read data is registered and appears one cycle after the request.

Top module: `amdma_regfile`

## Requirements
- R1: After synchronous reset every register reads zero, `xfer_start` is low and `main_addr`, `aux_addr`, `xfer_count` and `rd_data` are zero.
- R2: The info (offset 0x000), mode (0x002) and refresh (0x004) registers return all 16 bits exactly as last written.
- R3: The upper halves of main address (0x010), auxiliary address (0x014) and count (0x018) store all 16 written bits, and a halfword write to either half of a 32-bit value leaves the other half unchanged.
- R4: A write to a lower half, main address (0x012), auxiliary address (0x016) or count (0x01A), stores the data ANDed with 0xFFE0, so bits 4:0 of all three 32-bit values are always zero.
- R5: A write that touches the count lower half (0x01A) raises `xfer_start` for exactly one cycle, the cycle after the write is accepted, while `xfer_count` already shows the new value with the upper half kept.
- R6: Writes to any other offset, including the count upper half, never raise `xfer_start`.
- R7: A word access (`req_wide`=1) uses offset bits 11:2; `req_wdata[31:16]` goes to that 4-aligned offset and `req_wdata[15:0]` to the offset plus 2; a word write at 0x018 loads the whole count and gives exactly one start pulse.
- R8: Read data appears on `rd_data` the cycle after a read request and is zero in other cycles; a halfword read (offset bit 0 ignored) returns the register in bits 15:0 with bits 31:16 zero; a word read returns the register at the aligned offset in bits 31:16 and the one at offset plus 2 in bits 15:0.
- R9: A read of an unmapped offset returns zero and a write to an unmapped offset changes no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 32-bit access, 0 = 16-bit access |
| req_offset | input | 12 | Byte offset inside the 4 KB window |
| req_wdata | input | 32 | Write data; halfword writes use bits 15:0 |
| rd_data | output | 32 | Registered read data, valid the cycle after a read |
| xfer_start | output | 1 | One-cycle launch pulse to the transfer engine |
| main_addr | output | 32 | Main-memory address, 32-byte aligned |
| aux_addr | output | 32 | Auxiliary-memory address, 32-byte aligned |
| xfer_count | output | 32 | Transfer byte count, 32-byte aligned |

## Verification
The bench targets the places where the split halves interact: a lower-half write with the low five bits set (a design that skipped the mask would expose unaligned addresses), a halfword write to one half after the other was loaded (a design that cleared the sibling half would corrupt the 32-bit value), and a word write to the count (a design that fired on the upper half or fired twice would launch early or double-launch). It also hits unaligned word offsets, odd halfword offsets and unmapped offsets, where a wrong decode would either alias onto a live register or return stale data instead of zero.

// File: rtl/amdma_pkg.sv
package amdma_pkg;

    localparam int OFFS_W     = 12;
    localparam int HALF_W     = 16;
    localparam int WORD_W     = 2 * HALF_W;
    localparam int ALIGN_BITS = 5;
    localparam int NREG       = 9;

    // register indices
    localparam int RI_INFO    = 0;
    localparam int RI_MODE    = 1;
    localparam int RI_REFR    = 2;
    localparam int RI_MAIN_HI = 3;
    localparam int RI_MAIN_LO = 4;
    localparam int RI_AUX_HI  = 5;
    localparam int RI_AUX_LO  = 6;
    localparam int RI_CNT_HI  = 7;
    localparam int RI_CNT_LO  = 8;

    // byte offsets; each upper half sits 2 below its lower half
    localparam logic [OFFS_W-1:0] OFF_INFO    = 12'h000;
    localparam logic [OFFS_W-1:0] OFF_MODE    = 12'h002;
    localparam logic [OFFS_W-1:0] OFF_REFR    = 12'h004;
    localparam logic [OFFS_W-1:0] OFF_MAIN_HI = 12'h010;
    localparam logic [OFFS_W-1:0] OFF_MAIN_LO = 12'h012;
    localparam logic [OFFS_W-1:0] OFF_AUX_HI  = 12'h014;
    localparam logic [OFFS_W-1:0] OFF_AUX_LO  = 12'h016;
    localparam logic [OFFS_W-1:0] OFF_CNT_HI  = 12'h018;
    localparam logic [OFFS_W-1:0] OFF_CNT_LO  = 12'h01A;

    localparam logic [HALF_W-1:0] ALIGN_MASK = ~HALF_W'((1 << ALIGN_BITS) - 1);

    // one halfword access derived from a bus request
    typedef struct packed {
        logic              en;
        logic [OFFS_W-1:0] offs;
        logic [HALF_W-1:0] data;
    } half_acc_t;

    function automatic logic [OFFS_W-1:0] reg_offset(input int idx);
        case (idx)
            RI_INFO:    return OFF_INFO;
            RI_MODE:    return OFF_MODE;
            RI_REFR:    return OFF_REFR;
            RI_MAIN_HI: return OFF_MAIN_HI;
            RI_MAIN_LO: return OFF_MAIN_LO;
            RI_AUX_HI:  return OFF_AUX_HI;
            RI_AUX_LO:  return OFF_AUX_LO;
            RI_CNT_HI:  return OFF_CNT_HI;
            default:    return OFF_CNT_LO;
        endcase
    endfunction

    function automatic logic [HALF_W-1:0] reg_wmask(input int idx);
        case (idx)
            RI_MAIN_LO, RI_AUX_LO, RI_CNT_LO: return ALIGN_MASK;
            default:                          return '1;
        endcase
    endfunction

endpackage

// File: rtl/amdma_decode.sv
module amdma_decode
    import amdma_pkg::*;
(
    input  half_acc_t       acc,
    output logic [NREG-1:0] hit
);
    genvar g;
    generate
        for (g = 0; g < NREG; g++) begin : g_cmp
            localparam logic [OFFS_W-1:0] ROFF = reg_offset(g);
            assign hit[g] = acc.en && (acc.offs[OFFS_W-1:1] == ROFF[OFFS_W-1:1]);
        end
    endgenerate

    always_comb begin
        assert ($onehot0(hit)) else $error("decode overlap");
    end
endmodule

// File: rtl/amdma_half_reg.sv
module amdma_half_reg #(
    parameter int          W     = 16,
    parameter logic [W-1:0] WMASK = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [W-1:0] wd,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)     q <= '0;
        else if (we) q <= wd & WMASK;
    end
endmodule

// File: rtl/amdma_rdmux.sv
module amdma_rdmux
    import amdma_pkg::*;
(
    input  logic [NREG-1:0]             hit,
    input  logic [NREG-1:0][HALF_W-1:0] regs,
    output logic [HALF_W-1:0]           data
);
    always_comb begin
        data = '0;
        for (int i = 0; i < NREG; i++) begin
            if (hit[i]) data = data | regs[i];
        end
    end
endmodule

// File: rtl/amdma_regfile.sv
module amdma_regfile
    import amdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_wide,
    input  logic [OFFS_W-1:0] req_offset,
    input  logic [WORD_W-1:0] req_wdata,
    output logic [WORD_W-1:0] rd_data,
    output logic              xfer_start,
    output logic [WORD_W-1:0] main_addr,
    output logic [WORD_W-1:0] aux_addr,
    output logic [WORD_W-1:0] xfer_count
);
    half_acc_t                   acc_hi, acc_lo;
    logic [NREG-1:0]             hit_hi, hit_lo;
    logic [NREG-1:0][HALF_W-1:0] regs;
    logic [HALF_W-1:0]           rd_hi, rd_lo;
    logic                        cnt_lo_touched;

    // split a request into up to two halfword accesses
    always_comb begin
        acc_hi.en   = req_valid;
        acc_hi.offs = req_wide ? {req_offset[OFFS_W-1:2], 2'b00}
                               : {req_offset[OFFS_W-1:1], 1'b0};
        acc_hi.data = req_wide ? req_wdata[WORD_W-1:HALF_W] : req_wdata[HALF_W-1:0];
        acc_lo.en   = req_valid && req_wide;
        acc_lo.offs = {req_offset[OFFS_W-1:2], 2'b10};
        acc_lo.data = req_wdata[HALF_W-1:0];
    end

    amdma_decode u_dec_hi (.acc(acc_hi), .hit(hit_hi));
    amdma_decode u_dec_lo (.acc(acc_lo), .hit(hit_lo));

    genvar g;
    generate
        for (g = 0; g < NREG; g++) begin : g_reg
            logic              we;
            logic [HALF_W-1:0] wd;
            assign we = req_write && (hit_hi[g] || hit_lo[g]);
            assign wd = hit_lo[g] ? acc_lo.data : acc_hi.data;
            amdma_half_reg #(.W(HALF_W), .WMASK(reg_wmask(g))) u_reg (
                .clk(clk), .rst(rst), .we(we), .wd(wd), .q(regs[g])
            );
        end
    endgenerate

    amdma_rdmux u_rd_hi (.hit(hit_hi), .regs(regs), .data(rd_hi));
    amdma_rdmux u_rd_lo (.hit(hit_lo), .regs(regs), .data(rd_lo));

    assign cnt_lo_touched = hit_hi[RI_CNT_LO] || hit_lo[RI_CNT_LO];

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data    <= '0;
            xfer_start <= 1'b0;
        end else begin
            if (req_valid && !req_write)
                rd_data <= req_wide ? {rd_hi, rd_lo} : {{HALF_W{1'b0}}, rd_hi};
            else
                rd_data <= '0;
            xfer_start <= req_valid && req_write && cnt_lo_touched;
        end
    end

    assign main_addr  = {regs[RI_MAIN_HI], regs[RI_MAIN_LO]};
    assign aux_addr   = {regs[RI_AUX_HI],  regs[RI_AUX_LO]};
    assign xfer_count = {regs[RI_CNT_HI],  regs[RI_CNT_LO]};

    // ---------------- assertions ----------------
    p_lo_aligned_r4: assert property (@(posedge clk) disable iff (rst)
        main_addr[ALIGN_BITS-1:0] == '0 && aux_addr[ALIGN_BITS-1:0] == '0 &&
        xfer_count[ALIGN_BITS-1:0] == '0);

    p_start_follows_write_r5: assert property (@(posedge clk) disable iff (rst)
        xfer_start |-> $past(req_valid && req_write));

    p_cnt_hi_no_start_r6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && !req_wide &&
         req_offset[OFFS_W-1:1] == OFF_CNT_HI[OFFS_W-1:1]) |=> !xfer_start);

    p_hi_keeps_lo_r3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && !req_wide &&
         req_offset[OFFS_W-1:1] == OFF_CNT_HI[OFFS_W-1:1])
        |=> xfer_count[HALF_W-1:0] == $past(xfer_count[HALF_W-1:0]));

    p_narrow_read_upper_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && !req_wide) |=> rd_data[WORD_W-1:HALF_W] == '0);

    p_unmapped_read_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && !req_wide && hit_hi == '0) |=> rd_data == '0);

    p_no_req_no_start_r6: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !xfer_start);
endmodule

// File: tb/test_amdma_regfile.sv
module test_amdma_regfile;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0, req_wide = 1'b0;
    logic [11:0] req_offset = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rd_data, main_addr, aux_addr, xfer_count;
    logic        xfer_start;

    int tests = 0, fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    amdma_regfile i_amdma_regfile (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_wide(req_wide), .req_offset(req_offset), .req_wdata(req_wdata),
        .rd_data(rd_data), .xfer_start(xfer_start), .main_addr(main_addr),
        .aux_addr(aux_addr), .xfer_count(xfer_count)
    );

    // ---------------- reference model ----------------
    logic [15:0] mdl [int];
    logic [31:0] exp_rd;
    logic        exp_start;

    function automatic bit mapped(int o);
        case (o)
            'h000, 'h002, 'h004, 'h010, 'h012, 'h014, 'h016, 'h018, 'h01A: return 1;
            default: return 0;
        endcase
    endfunction

    function automatic logic [15:0] mget(int o);
        return mapped(o) ? mdl[o] : 16'h0000;
    endfunction

    task automatic mput(int o, logic [15:0] d);
        if (o == 'h012 || o == 'h016 || o == 'h01A) mdl[o] = d & 16'hFFE0;
        else if (mapped(o))                         mdl[o] = d;
    endtask

    always @(posedge clk) begin
        if (rst) begin
            foreach (mdl[k]) mdl[k] = 16'h0000;
            for (int o = 0; o < 'h20; o += 2) if (mapped(o)) mdl[o] = 16'h0000;
            exp_rd = '0;
            exp_start = 1'b0;
        end else begin
            exp_rd = '0;
            exp_start = 1'b0;
            if (req_valid) begin
                int hi_o, lo_o;
                if (req_wide) begin
                    hi_o = int'(req_offset) & ~3;
                    lo_o = hi_o + 2;
                    if (!req_write) exp_rd = {mget(hi_o), mget(lo_o)};
                    else begin
                        mput(hi_o, req_wdata[31:16]);
                        mput(lo_o, req_wdata[15:0]);
                        exp_start = (lo_o == 'h01A);
                    end
                end else begin
                    hi_o = int'(req_offset) & ~1;
                    if (!req_write) exp_rd = {16'h0000, mget(hi_o)};
                    else begin
                        mput(hi_o, req_wdata[15:0]);
                        exp_start = (hi_o == 'h01A);
                    end
                end
            end
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] expv);
        tests++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, expv);
        end
    endtask

    // every-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R5 start vs model", {31'd0, xfer_start}, {31'd0, exp_start});
            chk("R8 rd_data vs model", rd_data, exp_rd);
            chk("R3 main_addr vs model", main_addr, {mget('h010), mget('h012)});
            chk("R3 aux_addr vs model", aux_addr, {mget('h014), mget('h016)});
            chk("R4 count vs model", xfer_count, {mget('h018), mget('h01A)});
        end
    end

    // ---------------- bus tasks: return at the negedge after the edge ----------------
    task automatic bus(bit wr, bit wide, logic [11:0] off, logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_wide = wide; req_offset = off; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; req_wide = 1'b0; req_offset = '0; req_wdata = '0;
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic summary();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        chk("R1 start after reset", {31'd0, xfer_start}, 32'd0);
        chk("R1 count after reset", xfer_count, 32'd0);
        chk("R1 main after reset", main_addr, 32'd0);
        bus(0, 0, 12'h018, '0);
        chk("R1 count hi reads zero", rd_data, 32'd0);

        // R2 plain registers
        bus(1, 0, 12'h000, 32'h0000_A5C3);
        bus(1, 0, 12'h002, 32'h0000_FFFF);
        bus(1, 0, 12'h004, 32'h0000_009C);
        bus(0, 0, 12'h000, '0); chk("R2 info readback", rd_data, 32'h0000_A5C3);
        bus(0, 0, 12'h002, '0); chk("R2 mode readback", rd_data, 32'h0000_FFFF);
        bus(0, 0, 12'h004, '0); chk("R2 refresh readback", rd_data, 32'h0000_009C);

        // R3/R4 halves and alignment
        bus(1, 0, 12'h012, 32'h0000_1234);
        chk("R6 main lo no start", {31'd0, xfer_start}, 32'd0);
        bus(1, 0, 12'h010, 32'h0000_DEAD);
        chk("R3 main hi keeps lo", main_addr, 32'hDEAD_1220);
        bus(0, 0, 12'h012, '0); chk("R4 main lo masked", rd_data, 32'h0000_1220);
        bus(1, 0, 12'h016, 32'h0000_FFFF);
        bus(1, 0, 12'h014, 32'h0000_0007);
        chk("R4 aux masked", aux_addr, 32'h0007_FFE0);

        // R5/R6 count and start
        bus(1, 0, 12'h018, 32'h0000_0003);
        chk("R6 count hi no start", {31'd0, xfer_start}, 32'd0);
        bus(1, 0, 12'h01A, 32'h0000_0047);
        chk("R5 start pulse", {31'd0, xfer_start}, 32'd1);
        chk("R5 count with pulse", xfer_count, 32'h0003_0040);
        idle();
        chk("R5 pulse one cycle", {31'd0, xfer_start}, 32'd0);

        // R7 word accesses
        bus(1, 1, 12'h018, 32'h0001_0123);
        chk("R7 word count start", {31'd0, xfer_start}, 32'd1);
        chk("R7 word count value", xfer_count, 32'h0001_0120);
        idle();
        chk("R7 single start", {31'd0, xfer_start}, 32'd0);
        bus(1, 1, 12'h012, 32'hCAFE_BEEF);
        chk("R7 unaligned word goes to 0x010", main_addr, 32'hCAFE_BEE0);
        chk("R6 main word no start", {31'd0, xfer_start}, 32'd0);

        // R8 reads
        bus(0, 1, 12'h014, '0); chk("R8 word read aux", rd_data, 32'h0007_FFE0);
        bus(0, 0, 12'h013, '0); chk("R8 odd halfword offset", rd_data, 32'h0000_BEE0);
        bus(0, 1, 12'h000, '0); chk("R8 word read info/mode", rd_data, 32'hA5C3_FFFF);
        idle(); chk("R8 rd zero when idle", rd_data, 32'd0);

        // R9 unmapped
        bus(1, 0, 12'h040, 32'h0000_5555);
        chk("R9 unmapped write no start", {31'd0, xfer_start}, 32'd0);
        bus(0, 0, 12'h040, '0); chk("R9 unmapped read zero", rd_data, 32'd0);
        bus(1, 1, 12'hFFC, 32'h1234_5678);
        bus(0, 1, 12'hFFC, '0); chk("R9 unmapped word read zero", rd_data, 32'd0);
        chk("R9 count untouched", xfer_count, 32'h0001_0120);

        // back-to-back triggers
        bus(1, 0, 12'h01A, 32'h0000_FFFF);
        chk("R5 second trigger", {31'd0, xfer_start}, 32'd1);
        bus(1, 0, 12'h01A, 32'h0000_0020);
        chk("R5 third trigger", {31'd0, xfer_start}, 32'd1);
        chk("R5 count after retrigger", xfer_count, 32'h0001_0020);

        // R1 reset mid-run
        @(negedge clk) rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        chk("R1 reset clears main", main_addr, 32'd0);
        chk("R1 reset clears count", xfer_count, 32'd0);
        bus(0, 0, 12'h004, '0); chk("R1 reset clears refresh", rd_data, 32'd0);

        idle();
        summary();
    end
endmodule